// File: doc/BRIEF.md
# Interrupt Cycle Controller

This controller sits between the instruction sequencer and the memory port of a small accumulator-style processor. At the end of every execute phase the sequencer raises a completion strobe. The controller then decides between two paths. If interrupts are enabled and a request is pending, it runs an interrupt cycle. Otherwise it hands control straight back to fetch.

The interrupt cycle has three steps. First the current program counter is captured into the memory buffer register. Next that value is written to a fixed save location. Last the program counter is redirected to a fixed service-routine address. A separate return strobe reads the save location back and reloads the program counter from it. Entry clears the enable flag, so the routine is not entered a second time before it returns. Only an explicit enable input sets the flag again. A request that arrives while the controller is busy, or while interrupts are disabled, is held until an execute completion finds both conditions true.

Top module: `irq_cycle_ctrl`

## Requirements
- R1: When `exec_done` is high with the controller idle, `ret_req` low, `irq_en` high and a request present (`irq_pend` high, or `irq_req` high in the same cycle), `busy` is high for exactly the next three cycles.
- R2: When `exec_done` is high with the controller idle, `ret_req` low and no enabled pending request, `fetch_go` is high in the next cycle and `busy` stays low.
- R3: In the second busy cycle of an entry, `mem_we` is high, `mem_addr` equals SAVE_ADDR, and `mem_wdata` equals `pc_cur` as it was in the first busy cycle, zero-extended to DATA_W.
- R4: In the third busy cycle of an entry, `pc_load` is high with `pc_load_val` equal to ISR_ADDR. `fetch_go` is high in the cycle after that.
- R5: `irq_en` is cleared by an entry and set by `ien_set`. If both happen in the same cycle, the clear wins.
- R6: `irq_req` sets `irq_pend` in the next cycle unless the request is consumed by an entry in that same cycle. `irq_pend` is kept while the controller is busy or disabled, and is cleared only by an entry.
- R7: `ret_req` with the controller idle gives `mem_re` high with `mem_addr` equal to SAVE_ADDR in the next cycle. In the cycle after that, `pc_load` is high with `pc_load_val` equal to the low ADDR_W bits of `mem_rdata`, which the memory returns one cycle after `mem_re`. `fetch_go` follows one cycle later, and `busy` is high during the two middle cycles.
- R8: If `ret_req` and `exec_done` are both high while idle, the return is started and the completion is not acted on.
- R9: `exec_done` and `ret_req` have no effect while `busy` is high.
- R10: After reset the controller is idle, with `irq_en`, `irq_pend`, `busy`, `mem_we`, `mem_re`, `pc_load` and `fetch_go` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_done | input | 1 | Execute phase of current instruction complete |
| irq_req | input | 1 | Interrupt request pulse |
| ien_set | input | 1 | Set the interrupt enable flag |
| ret_req | input | 1 | Return from service routine |
| pc_cur | input | ADDR_W | Current program counter value |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after mem_re |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | ADDR_W | Value to load into the program counter |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory address register contents |
| mem_wdata | output | DATA_W | Memory buffer register contents |
| fetch_go | output | 1 | Resume instruction fetch |
| busy | output | 1 | Interrupt entry or return in progress |
| irq_en | output | 1 | Interrupt enable flag |
| irq_pend | output | 1 | Latched pending request |

## Verification
Every result is registered, so each result falls a whole number of cycles after its stimulus. A plain completion produces `fetch_go` one cycle later. An entry produces `busy` in cycles 1 to 3, the memory write in cycle 2, the program counter load in cycle 3 and `fetch_go` in cycle 4. A return produces the read in cycle 1, the reload in cycle 2 and `fetch_go` in cycle 3. The flags change one cycle after their cause. The bench drives inputs on falling edges. A behavioural model advances its phase counter on each rising edge, and every output is compared against it on the next falling edge, so each value is checked in exactly the cycle it is due. Directed checks also count busy cycles and read the saved word and the reloaded program counter back through the memory and PC ports.

// File: rtl/irq_cyc_pkg.sv
package irq_cyc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CAP  = 3'd1,
      PH_WR   = 3'd2,
      PH_LD   = 3'd3,
      PH_RD   = 3'd4,
      PH_RLD  = 3'd5
   } ph_t;
endpackage

// File: rtl/irq_cyc_flags.sv
module irq_cyc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_req,
   input  logic ien_set,
   input  logic take,
   output logic irq_en,
   output logic irq_pend
);
   // entry clears both flags; the clear outranks a same-cycle set
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en   <= 1'b0;
         irq_pend <= 1'b0;
      end else begin
         if (take)         irq_en <= 1'b0;
         else if (ien_set) irq_en <= 1'b1;

         if (take)         irq_pend <= 1'b0;
         else if (irq_req) irq_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_cyc_seq.sv
module irq_cyc_seq
   import irq_cyc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic exec_done,
   input  logic ret_req,
   input  logic irq_en,
   input  logic irq_pend,
   input  logic irq_req,
   output logic take,
   output logic ret_go,
   output ph_t  ph,
   output logic fetch_go
);
   ph_t  ph_nxt;
   logic idle;
   logic plain_done;

   assign idle       = (ph == PH_IDLE);
   assign ret_go     = idle && ret_req;
   assign take       = idle && !ret_req && exec_done && irq_en && (irq_pend || irq_req);
   assign plain_done = idle && !ret_req && exec_done && !take;

   always_comb begin
      ph_nxt = ph;
      unique case (ph)
         PH_IDLE: begin
            if (ret_go)    ph_nxt = PH_RD;
            else if (take) ph_nxt = PH_CAP;
         end
         PH_CAP:  ph_nxt = PH_WR;
         PH_WR:   ph_nxt = PH_LD;
         PH_LD:   ph_nxt = PH_IDLE;
         PH_RD:   ph_nxt = PH_RLD;
         PH_RLD:  ph_nxt = PH_IDLE;
         default: ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         fetch_go <= 1'b0;
      end else begin
         ph       <= ph_nxt;
         fetch_go <= plain_done || (ph == PH_LD) || (ph == PH_RLD);
      end
   end
endmodule

// File: rtl/irq_cyc_dp.sv
module irq_cyc_dp
   import irq_cyc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 16,
   parameter int SAVE_ADDR = 0,
   parameter int ISR_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ph_t               ph,
   input  logic              take,
   input  logic              ret_go,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_load_val,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
   localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_ADDR);

   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mbr_q;
   logic [DATA_W-1:0] pc_ext;
   logic [ADDR_W-1:0] rd_pc;

   generate
      if (DATA_W > ADDR_W) begin : g_pad
         logic unused_rd_hi;
         assign pc_ext       = {{(DATA_W-ADDR_W){1'b0}}, pc_cur};
         assign rd_pc        = mem_rdata[ADDR_W-1:0];
         assign unused_rd_hi = ^mem_rdata[DATA_W-1:ADDR_W];
      end else begin : g_flat
         assign pc_ext = pc_cur;
         assign rd_pc  = mem_rdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q <= '0;
         mbr_q <= '0;
      end else begin
         if (take || ret_go) mar_q <= SAVE_A;
         if (ph == PH_CAP)   mbr_q <= pc_ext;
      end
   end

   assign mem_addr    = mar_q;
   assign mem_wdata   = mbr_q;
   assign mem_we      = (ph == PH_WR);
   assign mem_re      = (ph == PH_RD);
   assign pc_load     = (ph == PH_LD) || (ph == PH_RLD);
   assign pc_load_val = (ph == PH_LD) ? ISR_A : rd_pc;
   assign busy        = (ph != PH_IDLE);
endmodule

// File: rtl/irq_cycle_ctrl.sv
module irq_cycle_ctrl
   import irq_cyc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 16,
   parameter int SAVE_ADDR = 0,
   parameter int ISR_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_done,
   input  logic              irq_req,
   input  logic              ien_set,
   input  logic              ret_req,
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_load_val,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              fetch_go,
   output logic              busy,
   output logic              irq_en,
   output logic              irq_pend
);
   generate
      if (ADDR_W < 2)
         $error("irq_cycle_ctrl: ADDR_W must be at least 2");
      if (DATA_W < ADDR_W)
         $error("irq_cycle_ctrl: DATA_W must hold a full program counter");
      if (SAVE_ADDR == ISR_ADDR)
         $error("irq_cycle_ctrl: save and routine addresses must differ");
      if (SAVE_ADDR < 0 || SAVE_ADDR >= (1 << ADDR_W))
         $error("irq_cycle_ctrl: SAVE_ADDR outside address range");
      if (ISR_ADDR < 0 || ISR_ADDR >= (1 << ADDR_W))
         $error("irq_cycle_ctrl: ISR_ADDR outside address range");
   endgenerate

   ph_t  ph;
   logic take;
   logic ret_go;

   irq_cyc_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .ien_set  (ien_set),
      .take     (take),
      .irq_en   (irq_en),
      .irq_pend (irq_pend)
   );

   irq_cyc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .exec_done (exec_done),
      .ret_req   (ret_req),
      .irq_en    (irq_en),
      .irq_pend  (irq_pend),
      .irq_req   (irq_req),
      .take      (take),
      .ret_go    (ret_go),
      .ph        (ph),
      .fetch_go  (fetch_go)
   );

   irq_cyc_dp #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SAVE_ADDR (SAVE_ADDR),
      .ISR_ADDR  (ISR_ADDR)
   ) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .ph          (ph),
      .take        (take),
      .ret_go      (ret_go),
      .pc_cur      (pc_cur),
      .mem_rdata   (mem_rdata),
      .pc_load     (pc_load),
      .pc_load_val (pc_load_val),
      .mem_we      (mem_we),
      .mem_re      (mem_re),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .busy        (busy)
   );
endmodule

// File: rtl/irq_cyc_chk.sv
module irq_cyc_chk #(
   parameter int ADDR_W    = 12,
   parameter int SAVE_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_done,
   input logic              ret_req,
   input logic              irq_req,
   input logic              ien_set,
   input logic              irq_en,
   input logic              irq_pend,
   input logic              busy,
   input logic              fetch_go,
   input logic              mem_we,
   input logic              mem_re,
   input logic              pc_load,
   input logic [ADDR_W-1:0] mem_addr
);
   logic enter;
   logic plain;
   assign enter = exec_done && !busy && !ret_req && irq_en && (irq_pend || irq_req);
   assign plain = exec_done && !busy && !ret_req && !(irq_en && (irq_pend || irq_req));

   a_r1_enter_busy: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> busy);
   a_r2_plain_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      plain |=> (fetch_go && !busy));
   a_r3_save_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (busy && mem_addr == ADDR_W'(SAVE_ADDR)));
   a_r4_load_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (fetch_go && !busy));
   a_r5_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> !irq_en);
   a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_set && !enter) |=> irq_en);
   a_r6_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !enter) |=> irq_pend);
   a_r7_read_then_load: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> pc_load);
   a_r7_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (mem_addr == ADDR_W'(SAVE_ADDR)));
   a_r8_return_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && exec_done && !busy) |=> mem_re);
   a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re, pc_load}));
endmodule

bind irq_cycle_ctrl irq_cyc_chk #(
   .ADDR_W    (ADDR_W),
   .SAVE_ADDR (SAVE_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exec_done (exec_done),
   .ret_req   (ret_req),
   .irq_req   (irq_req),
   .ien_set   (ien_set),
   .irq_en    (irq_en),
   .irq_pend  (irq_pend),
   .busy      (busy),
   .fetch_go  (fetch_go),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .pc_load   (pc_load),
   .mem_addr  (mem_addr)
);

// File: tb/sim_irq_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cycle_ctrl;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int SAVE = 0;
   localparam int ISR = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exec_done = 1'b0, irq_req = 1'b0, ien_set = 1'b0, ret_req = 1'b0;
   logic [AW-1:0] pc_cur;
   logic [DW-1:0] mem_rdata;
   logic          pc_load, mem_we, mem_re, fetch_go, busy, irq_en, irq_pend;
   logic [AW-1:0] pc_load_val, mem_addr;
   logic [DW-1:0] mem_wdata;

   always #5 clk = ~clk;

   irq_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) u0 (
      .clk(clk), .rst_n(rst_n), .exec_done(exec_done), .irq_req(irq_req),
      .ien_set(ien_set), .ret_req(ret_req), .pc_cur(pc_cur), .mem_rdata(mem_rdata),
      .pc_load(pc_load), .pc_load_val(pc_load_val), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fetch_go(fetch_go), .busy(busy),
      .irq_en(irq_en), .irq_pend(irq_pend));

   // bench memory and program counter
   logic [DW-1:0] mem [0:15];
   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
   end
   always_ff @(posedge clk) begin
      if (!rst_n)        pc_cur <= 12'h100;
      else if (pc_load)  pc_cur <= pc_load_val;
      else if (fetch_go) pc_cur <= pc_cur + 12'd7;
   end

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: phase counter and flags
   int     m_ph = 0;       // 0 idle, 1..3 entry steps, 4..5 return steps
   bit     m_en = 0, m_pend = 0, m_fetch = 0;
   longint m_mbr = 0, m_saved = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_en <= 0; m_pend <= 0; m_fetch <= 0;
      end else begin
         bit tk;
         tk = (m_ph == 0) && !ret_req && exec_done && m_en && (m_pend || irq_req);
         m_fetch <= ((m_ph == 0) && !ret_req && exec_done && !tk) || m_ph == 3 || m_ph == 5;
         if (m_ph == 0)      m_ph <= ret_req ? 4 : (tk ? 1 : 0);
         else if (m_ph == 3 || m_ph == 5) m_ph <= 0;
         else                m_ph <= m_ph + 1;
         if (m_ph == 1) m_mbr <= pc_cur;
         if (m_ph == 2) m_saved <= m_mbr;
         m_en   <= tk ? 1'b0 : (ien_set ? 1'b1 : m_en);
         m_pend <= tk ? 1'b0 : (irq_req ? 1'b1 : m_pend);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(busy == (m_ph != 0), "R1 busy", busy, m_ph != 0);
         chk(fetch_go == m_fetch, "R2 fetch_go", fetch_go, m_fetch);
         chk(mem_we == (m_ph == 2), "R3 mem_we", mem_we, m_ph == 2);
         if (m_ph == 2) begin
            chk(mem_addr == SAVE, "R3 write addr", mem_addr, SAVE);
            chk(mem_wdata == m_mbr, "R3 write data", mem_wdata, m_mbr);
         end
         chk(pc_load == (m_ph == 3 || m_ph == 5), "R4 pc_load", pc_load, m_ph == 3 || m_ph == 5);
         if (m_ph == 3) chk(pc_load_val == ISR, "R4 routine addr", pc_load_val, ISR);
         chk(irq_en == m_en, "R5 irq_en", irq_en, m_en);
         chk(irq_pend == m_pend, "R6 irq_pend", irq_pend, m_pend);
         chk(mem_re == (m_ph == 4), "R7 mem_re", mem_re, m_ph == 4);
         if (m_ph == 4) chk(mem_addr == SAVE, "R7 read addr", mem_addr, SAVE);
         if (m_ph == 5) chk(pc_load_val == m_saved[AW-1:0], "R7 restore", pc_load_val, m_saved[AW-1:0]);
      end
   end

   task automatic drive(input bit e, input bit q, input bit s, input bit r);
      exec_done = e; irq_req = q; ien_set = s; ret_req = r;
      @(negedge clk);
      exec_done = 0; irq_req = 0; ien_set = 0; ret_req = 0;
   endtask

   task automatic idle_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [AW-1:0] pc_before;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy && !irq_en && !irq_pend && !mem_we && !mem_re && !pc_load && !fetch_go,
          "R10 reset state", {busy, irq_en, irq_pend, mem_we, mem_re, pc_load, fetch_go}, 0);

      // R2 plain completion, disabled
      drive(1, 0, 0, 0);
      chk(fetch_go && !busy, "R2 plain completion", {fetch_go, busy}, 2'b10);
      idle_n(2);

      // R6 request held while disabled
      drive(0, 1, 0, 0);
      drive(1, 0, 0, 0);
      chk(irq_pend && !busy, "R6 held while disabled", {irq_pend, busy}, 2'b10);
      idle_n(2);

      // R1 R3 R4 R5 entry
      drive(0, 0, 1, 0);
      pc_before = pc_cur;
      drive(1, 0, 0, 0);
      chk(busy && !irq_en && !irq_pend, "R5 entry clears flags", {busy, irq_en, irq_pend}, 3'b100);
      // R9 exec_done and a new request during busy
      drive(1, 1, 0, 0);
      idle_n(1);
      chk(pc_load && pc_load_val == ISR, "R4 routine load", pc_load_val, ISR);
      idle_n(1);
      chk(fetch_go && !busy, "R9 busy window of three", busy, 0);
      chk(mem[SAVE] == DW'(pc_before), "R3 saved word", mem[SAVE], pc_before);
      chk(pc_cur == ISR, "R4 pc redirected", pc_cur, ISR);
      chk(irq_pend && !irq_en, "R6 request kept from busy", {irq_pend, irq_en}, 2'b10);
      idle_n(2);

      // R5 enable set same cycle as entry: clear wins
      drive(0, 0, 1, 0);
      drive(1, 0, 1, 0);
      chk(busy && !irq_en, "R5 clear beats set", irq_en, 0);
      idle_n(4);

      // R7 return
      drive(0, 0, 0, 1);
      chk(mem_re && busy, "R7 read strobe", mem_re, 1);
      idle_n(1);
      chk(pc_load && pc_load_val == mem[SAVE][AW-1:0], "R7 reload", pc_load_val, mem[SAVE][AW-1:0]);
      idle_n(1);
      chk(pc_cur == mem[SAVE][AW-1:0], "R7 pc restored", pc_cur, mem[SAVE][AW-1:0]);
      idle_n(1);

      // R8 return beats completion
      drive(0, 1, 1, 0);
      drive(1, 0, 0, 1);
      chk(mem_re && irq_en && irq_pend, "R8 return taken", {mem_re, irq_en, irq_pend}, 3'b111);
      // R9 return request while busy ignored
      drive(0, 0, 0, 1);
      idle_n(1);
      chk(!busy && !mem_re, "R9 return during busy ignored", {busy, mem_re}, 0);
      idle_n(2);

      // R1 request and completion in the same cycle
      drive(1, 1, 0, 0);
      chk(busy, "R1 same-cycle request", busy, 1);
      idle_n(5);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         bit e, q, s, r;
         e = ($urandom_range(0, 2) == 0);
         q = ($urandom_range(0, 5) == 0);
         s = ($urandom_range(0, 4) == 0);
         r = ($urandom_range(0, 9) == 0);
         drive(e, q, s, r);
      end
      idle_n(6);
      finish_run();
   end
endmodule